// File: doc/BRIEF.md
# Instruction Cache Control and Invalidation Sequencer

This block is the software-facing control and status unit of an instruction cache. Through a small word-addressed register bus, software turns the cache on and off and picks between direct-mapped and two-way set-associative operation. It can also start a full invalidation and watch a busy indication and a completion flag. A second register masks the error and completion sources onto one interrupt line. A third register clears pending flags when a 1 is written to the matching bit.

Invalidation and disable are both carried out as a walk over `LINES` tag lines, one line per clock. On each step the block presents a clear strobe and a line index to the tag array that sits outside it. A sequencer with three states drives the walk. `S_IDLE` leaves for `S_INVAL` on an accepted invalidate request (transition *inv_start*). `S_IDLE` leaves for `S_DISABLE` when the enable bit is written from 1 to 0 (transition *dis_start*); if both happen in one write, *dis_start* takes priority. Either busy state returns to `S_IDLE` once it has cleared the last line (transition *walk_end*), and that raises the completion flag. The error flag is set by an external one-cycle error pulse.

Register map (word index on `bus_addr`):
- 0, control: bit 0 enable, bit 1 invalidate (write 1 to launch; reads 1 only while an invalidation walk runs), bit 2 way select (1 = two-way, 0 = direct-mapped).
- 1, status (read only): bit 0 busy, bit 1 completion flag, bit 2 error flag.
- 2, interrupt enable: bit 1 completion source, bit 2 error source.
- 3, flag clear (write only, reads 0): bit 1 clears completion, bit 2 clears error.

Top module: `icache_ctl`

## Requirements
- R1: After reset the control register reads 4 (disabled, two-way), status reads 0, interrupt enable reads 0, `irq` is 0 and `line_clr` is 0.
- R2: While enable (control bit 0) is 0 before a write, a control write loads way select (bit 2) from the written data.
- R3: While enable is 1, a control write leaves way select unchanged.
- R4: An accepted invalidate request (control write with bit 1 set, block idle) makes busy (status bit 0) 1 from the next cycle for exactly `LINES` cycles. During those cycles `line_clr` is 1 and `line_idx` counts 0 to `LINES`-1 in ascending order.
- R5: Control bit 1 reads 1 only during an invalidation walk. When the walk ends, the completion flag (status bit 1) is set in the cycle busy drops.
- R6: An invalidate request made while busy is ignored: the running walk is neither restarted nor lengthened.
- R7: Writing enable from 1 to 0 while idle starts a disable walk of `LINES` cycles with busy held, `line_clr` active and control bit 1 reading 0. At its end the completion flag is set.
- R8: A control write that sets enable while busy is ignored for the enable bit.
- R9: A one-cycle `err_pulse` sets the error flag (status bit 2) from the next cycle, and the flag stays set until it is cleared.
- R10: Writing the flag-clear register clears each flag whose bit is 1 and leaves flags whose bit is 0. A set event in the same cycle as its clear wins. The flag-clear register reads 0.
- R11: `irq` is 1 exactly when some flag (status bit 1 or 2) is set and its interrupt-enable bit (same position) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| err_pulse | input | 1 | One-cycle error event from the cache datapath |
| irq | output | 1 | Interrupt request |
| line_clr | output | 1 | Clear the valid bit of line `line_idx` this cycle |
| line_idx | output | LINE_W | Tag line being cleared |

## Verification
Each register write takes effect at the clock edge that samples it. Control bits, busy, `line_clr` and `line_idx` therefore show the new value one cycle after the write. A walk keeps busy for `LINES` cycles from that point, and the completion flag is visible in the first cycle busy reads 0. The error flag follows `err_pulse` one cycle later, and `irq` follows the flags and enables in the same cycle because it is combinational. The bench drives each access for one cycle and samples at the falling edge after the capturing edge. It steps the walk one falling edge per line, checking the index at every step, and it counts clear strobes to prove that ignored requests neither lengthen nor restart a walk.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_INVAL,
        S_DISABLE
    } seq_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_IEN  = 2'd2;
    localparam logic [1:0] REG_FCLR = 2'd3;

    localparam int CB_EN   = 0;
    localparam int CB_INV  = 1;
    localparam int CB_WAY  = 2;
    localparam int SB_BUSY = 0;
    localparam int SB_BEND = 1;
    localparam int SB_ERR  = 2;

    localparam int NSRC = 2;

endpackage

// File: rtl/icc_seq.sv
module icc_seq
    import icc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_inv,
    input  logic              start_dis,
    output logic              busy,
    output logic              inv_active,
    output logic              line_clr,
    output logic [LINE_W-1:0] line_idx,
    output logic              done
);

    localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);

    seq_state_t        state_q, state_d;
    logic [LINE_W-1:0] cnt_q;
    logic              at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state_q == S_IDLE) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_dis)      state_d = S_DISABLE;
                else if (start_inv) state_d = S_INVAL;
            end
            S_INVAL:   if (at_last) state_d = S_IDLE;
            S_DISABLE: if (at_last) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        inv_active = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_INVAL: begin
                busy       = 1'b1;
                inv_active = 1'b1;
                done       = at_last;
            end
            S_DISABLE: begin
                busy = 1'b1;
                done = at_last;
            end
            default: ;
        endcase
        line_clr = busy;
        line_idx = cnt_q;
    end

endmodule

// File: rtl/icc_flags.sv
module icc_flags
    import icc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] ien_i,
    output logic [NSRC-1:0] flag_o,
    output logic            irq
);

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[g] <= 1'b0;
            else if (set_i[g]) flag_o[g] <= 1'b1;
            else if (clr_i[g]) flag_o[g] <= 1'b0;
        end
    end

    assign irq = |(flag_o & ien_i);

endmodule

// File: rtl/icache_ctl.sv
module icache_ctl
    import icc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    parameter int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              err_pulse,
    output logic              irq,
    output logic              line_clr,
    output logic [LINE_W-1:0] line_idx
);

    localparam int LW = LINE_W;

    logic en_q, way_q;
    logic [NSRC-1:0] ien_q;
    logic [NSRC-1:0] flags;
    logic busy, inv_active, done;
    logic wr_ctrl, wr_ien, wr_fclr;
    logic start_inv, start_dis;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:3] ^ bus_wdata[0];

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign wr_ien  = bus_sel && bus_wr && (bus_addr == REG_IEN);
    assign wr_fclr = bus_sel && bus_wr && (bus_addr == REG_FCLR);

    assign start_dis = wr_ctrl && !busy && en_q && !bus_wdata[CB_EN];
    assign start_inv = wr_ctrl && !busy && bus_wdata[CB_INV];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            way_q <= 1'b1;
            ien_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= busy ? (en_q & bus_wdata[CB_EN]) : bus_wdata[CB_EN];
                if (!en_q) way_q <= bus_wdata[CB_WAY];
            end
            if (wr_ien) ien_q <= bus_wdata[SB_ERR:SB_BEND];
        end
    end

    icc_seq #(.LINES(LINES), .LINE_W(LINE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_inv  (start_inv),
        .start_dis  (start_dis),
        .busy       (busy),
        .inv_active (inv_active),
        .line_clr   (line_clr),
        .line_idx   (line_idx),
        .done       (done)
    );

    icc_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({err_pulse, done}),
        .clr_i  (wr_fclr ? bus_wdata[SB_ERR:SB_BEND] : 2'b00),
        .ien_i  (ien_q),
        .flag_o (flags),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CB_EN]  = en_q;
                bus_rdata[CB_INV] = inv_active;
                bus_rdata[CB_WAY] = way_q;
            end
            REG_STAT: begin
                bus_rdata[SB_BUSY]        = busy;
                bus_rdata[SB_ERR:SB_BEND] = flags;
            end
            REG_IEN:  bus_rdata[SB_ERR:SB_BEND] = ien_q;
            REG_FCLR: ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/icc_chk.sv
module icc_chk #(
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          line_clr,
    input logic [LW-1:0] line_idx,
    input logic          busy_end,
    input logic          error,
    input logic          err_pulse,
    input logic          en,
    input logic          way_sel
);

    // R4
    walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clr && $past(line_clr)) |-> (line_idx == LW'($past(line_idx) + 1'b1)));

    // R4
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_clr) |-> (line_idx == '0));

    // R5
    end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_end);

    // R3
    way_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> $stable(way_sel));

    // R9
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(err_pulse));

endmodule

bind icache_ctl icc_chk #(.LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .line_clr  (line_clr),
    .line_idx  (line_idx),
    .busy_end  (flags[0]),
    .error     (flags[1]),
    .err_pulse (err_pulse),
    .en        (en_q),
    .way_sel   (way_q)
);

// File: tb/tb_icache_ctl.sv
module tb_icache_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 8;
    localparam int LW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          err_pulse = 1'b0;
    logic          irq;
    logic          line_clr;
    logic [LW-1:0] line_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int clr_cnt = 0;
    logic [31:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_ctl #(.LINES(LINES), .DATA_W(32), .LINE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_pulse(err_pulse), .irq(irq), .line_clr(line_clr), .line_idx(line_idx)
    );

    always @(negedge clk) if (line_clr) clr_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    // leaves enable 0, way 1; error and completion flags as requested
    task automatic set_flags(input logic bend, input logic err);
        wr(2'd3, 32'h6);
        if (err) begin
            err_pulse = 1'b1;
            step(1);
            err_pulse = 1'b0;
        end
        if (bend) begin
            wr(2'd0, 32'h6);
            step(LINES);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 32'h4);
        rd(2'd1, d); check("R1 status", d, 32'h0);
        rd(2'd2, d); check("R1 ien", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 line_clr", {31'b0, line_clr}, 32'h0);

        // R2 / R3 way select sweep over enable x written way
        for (int en = 0; en < 2; en++) begin
            for (int w = 0; w < 2; w++) begin
                wr(2'd0, 32'h4);
                if (en == 1) wr(2'd0, 32'h5);
                wr(2'd0, (w << 2) | en);
                rd(2'd0, d);
                if (en == 1) check("R3 way locked", {31'b0, d[2]}, 32'h1);
                else         check("R2 way load", {31'b0, d[2]}, w);
                if (en == 1) begin
                    wr(2'd0, 32'h4);
                    step(LINES + 1);
                end
                wr(2'd0, 32'h4);
            end
        end
        wr(2'd3, 32'h6);

        // R4 / R5 invalidation walk, stepped line by line
        clr_cnt = 0;
        wr(2'd0, 32'h6);
        for (int k = 0; k < LINES; k++) begin
            check("R4 line_clr", {31'b0, line_clr}, 32'h1);
            check("R4 line_idx", {29'b0, line_idx}, k);
            rd(2'd1, d); check("R4 busy", {31'b0, d[0]}, 32'h1);
            rd(2'd0, d); check("R5 inv bit while walking", {31'b0, d[1]}, 32'h1);
            step(1);
        end
        check("R4 line_clr after", {31'b0, line_clr}, 32'h0);
        rd(2'd1, d); check("R5 status at end", d, 32'h2);
        rd(2'd0, d); check("R5 inv bit after", d, 32'h4);
        check("R4 strobe count", clr_cnt, LINES);

        // R6 second request during walk ignored
        wr(2'd3, 32'h6);
        clr_cnt = 0;
        wr(2'd0, 32'h6);
        step(3);
        wr(2'd0, 32'h6);
        step(LINES);
        check("R6 strobe count", clr_cnt, LINES);
        rd(2'd1, d); check("R6 status", d, 32'h2);

        // R7 disable walk, R8 enable write ignored while busy
        wr(2'd0, 32'h5);
        wr(2'd3, 32'h6);
        clr_cnt = 0;
        wr(2'd0, 32'h4);
        rd(2'd1, d); check("R7 busy on disable", d, 32'h1);
        rd(2'd0, d); check("R7 inv bit reads 0", d, 32'h4);
        wr(2'd0, 32'h5);
        rd(2'd0, d); check("R8 enable ignored", {31'b0, d[0]}, 32'h0);
        step(LINES);
        check("R7 strobe count", clr_cnt, LINES);
        rd(2'd1, d); check("R7 status at end", d, 32'h2);

        // R9 error flag set by pulse and held
        wr(2'd3, 32'h6);
        err_pulse = 1'b1;
        step(1);
        err_pulse = 1'b0;
        rd(2'd1, d); check("R9 error set", d, 32'h4);
        step(5);
        rd(2'd1, d); check("R9 error held", d, 32'h4);

        // R10 clear sweep over all clear patterns
        for (int p = 0; p < 4; p++) begin
            set_flags(1'b1, 1'b1);
            wr(2'd3, p << 1);
            rd(2'd1, d);
            check("R10 selective clear", {30'b0, d[2:1]}, 3 & ~p);
        end
        set_flags(1'b0, 1'b0);
        err_pulse = 1'b1;
        wr(2'd3, 32'h4);
        err_pulse = 1'b0;
        rd(2'd1, d); check("R10 set wins over clear", d, 32'h4);
        rd(2'd3, d); check("R10 fclr reads 0", d, 32'h0);

        // R11 irq over all enable x flag combinations
        for (int ie = 0; ie < 4; ie++) begin
            for (int f = 0; f < 4; f++) begin
                wr(2'd2, ie << 1);
                set_flags(f[0], f[1]);
                rd(2'd1, d);
                check("R11 flags", {30'b0, d[2:1]}, f);
                check("R11 irq", {31'b0, irq}, ((ie & f) != 0) ? 1 : 0);
            end
        end

        summary();
    end

endmodule